// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block watches the serial bit stream of a facility data link for short repeating codewords that carry a six-bit message. Each codeword is 16 bits long. It is a run of eight ones, then a zero, then the six message bits, then a closing zero. Bits count only on a cycle where the bit strobe is high.

While the block is hunting, it checks every incoming bit for a codeword. Once it finds one, it stays aligned and evaluates a codeword position every 16 strobed bits. A message is trusted only when it fills at least 8 of the last 10 codeword positions. Empty or corrupt positions, and positions that carry a different message, count against it.

When a trusted message differs from the one held before, the block reports a new-message event. When that message also equals a programmable match value, it reports a match event as well. Each event can be suppressed by its own mask input. The accepted message is held on an output for a controlling agent to read.

Top module: `bom_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `msg_valid`, `new_pulse` and `match_pulse` are 0.
- R2: A codeword is 16 strobed bits. Taking the first received bit as bit 15, bits 15..8 are ones and bits 7 and 0 are zero. Bits 6..1 are the message, and bit 6 lands on `msg_out[5]`.
- R3: A message is not accepted when it fills only 7 of the last 10 positions. It is accepted on the position that brings it to 8.
- R4: Positions without a codeword, and positions carrying another message, count against a candidate. A candidate that still holds 8 of the last 10 positions is accepted.
- R5: When a message that has already been accepted is validated again, no event is raised and `msg_out` is unchanged.
- R6: `new_pulse` fires when the accepted message changes. The first message accepted after reset also counts as a change.
- R7: `match_pulse` fires together with an acceptance whose message equals `match_value`. It stays low when the two differ.
- R8: While `new_mask` or `match_mask` is 1, the corresponding pulse is suppressed. `msg_out` and `msg_valid` still update.
- R9: `bit_in` is ignored on cycles where `bit_valid` is 0.
- R10: Each pulse is high for exactly one cycle, the cycle after the strobe edge that completes the codeword.
- R11: The block realigns by hunting. After arbitrary leading bits or a corrupt position, the next codeword is found at any bit offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a valid data link bit |
| bit_in | input | 1 | Data link bit |
| match_value | input | 6 | Message value that raises the match event |
| new_mask | input | 1 | 1 suppresses the new-message pulse |
| match_mask | input | 1 | 1 suppresses the match pulse |
| msg_out | output | 6 | Last accepted message |
| msg_valid | output | 1 | A message has been accepted since reset |
| new_pulse | output | 1 | One-cycle pulse when the accepted message changes |
| match_pulse | output | 1 | One-cycle pulse when a new accepted message equals match_value |

## Verification
The hardest state to reach is a vote that only just succeeds. The history must hold exactly eight agreeing positions, with the other two split between a rival message and a corrupt word. The stimulus sets this up by interleaving one rival codeword and one all-zero word between repeats of the candidate. It then checks that the seventh agreeing position gives no event and the eighth does.

A corrupt word also drops alignment. That run therefore also exercises hunting to realign. Leading junk bits at a non-multiple-of-16 offset exercise it again.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int BOM_MSG_W = 6;

  // one codeword position: found flag plus payload
  typedef struct packed {
    logic                 ok;
    logic [BOM_MSG_W-1:0] msg;
  } slot_t;
endpackage

// File: rtl/bom_framer.sv
module bom_framer
  import bom_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_valid,
  input  logic  bit_in,
  output logic  pos_end,
  output slot_t pos_slot
);
  localparam int CW_W  = FLAG_W + BOM_MSG_W + 2;
  localparam int CNT_W = $clog2(CW_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CW_W - 1);

  logic [CW_W-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             cw_hit;

  always_comb begin
    sr_d   = {sr_q[CW_W-2:0], bit_in};
    cw_hit = (&sr_d[CW_W-1 -: FLAG_W]) & ~sr_d[CW_W-1-FLAG_W] & ~sr_d[0];
    // locked: judge only at the 16-bit boundary; hunting: any bit may end a position
    pos_end = bit_valid & ((cnt_q == LAST) | (~lock_q & cw_hit));
    pos_slot.ok  = cw_hit;
    pos_slot.msg = sr_d[BOM_MSG_W:1];
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (bit_valid) begin
      cnt_d = pos_end ? '0 : cnt_q + 1'b1;
      if (pos_end) lock_d = cw_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (bit_valid) begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/bom_vote.sv
module bom_vote
  import bom_pkg::*;
#(
  parameter int HIST_DEPTH = 10,
  parameter int VOTE_MIN   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pos_end,
  input  slot_t                pos_slot,
  output logic                 accept,
  output logic [BOM_MSG_W-1:0] cand
);
  localparam int KEEP = HIST_DEPTH - 1;
  localparam int VW   = $clog2(HIST_DEPTH + 1);
  localparam logic [VW-1:0] VMIN = VW'(VOTE_MIN);

  slot_t                hist_q [KEEP];
  slot_t                window [HIST_DEPTH];
  logic [HIST_DEPTH-1:0] agree;
  logic [VW-1:0]         votes;

  assign window[0] = pos_slot;
  assign cand      = pos_slot.msg;

  genvar gi;
  generate
    for (gi = 1; gi < HIST_DEPTH; gi++) begin : g_win
      assign window[gi] = hist_q[gi-1];
    end
    for (gi = 0; gi < HIST_DEPTH; gi++) begin : g_agree
      assign agree[gi] = window[gi].ok & (window[gi].msg == pos_slot.msg);
    end
  endgenerate

  always_comb begin
    votes = '0;
    for (int i = 0; i < HIST_DEPTH; i++) votes = votes + VW'(agree[i]);
    accept = pos_end & pos_slot.ok & (votes >= VMIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < KEEP; i++) hist_q[i] <= '0;
    end else if (pos_end) begin
      hist_q[0] <= pos_slot;
      for (int i = 1; i < KEEP; i++) hist_q[i] <= hist_q[i-1];
    end
  end
endmodule

// File: rtl/bom_rx.sv
module bom_rx
  import bom_pkg::*;
#(
  parameter int FLAG_W     = 8,
  parameter int HIST_DEPTH = 10,
  parameter int VOTE_MIN   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic [BOM_MSG_W-1:0] match_value,
  input  logic                 new_mask,
  input  logic                 match_mask,
  output logic [BOM_MSG_W-1:0] msg_out,
  output logic                 msg_valid,
  output logic                 new_pulse,
  output logic                 match_pulse
);
  logic                 pos_end, accept, take;
  slot_t                pos_slot;
  logic [BOM_MSG_W-1:0] cand;
  logic [BOM_MSG_W-1:0] acc_msg_q, acc_msg_d;
  logic                 acc_vld_q, acc_vld_d, new_q, new_d, match_q, match_d;

  bom_framer #(.FLAG_W(FLAG_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .pos_end(pos_end), .pos_slot(pos_slot)
  );

  bom_vote #(.HIST_DEPTH(HIST_DEPTH), .VOTE_MIN(VOTE_MIN)) u_vote (
    .clk(clk), .rst_n(rst_n), .pos_end(pos_end), .pos_slot(pos_slot),
    .accept(accept), .cand(cand)
  );

  always_comb begin
    take      = accept & (~acc_vld_q | (cand != acc_msg_q));
    acc_msg_d = take ? cand : acc_msg_q;
    acc_vld_d = acc_vld_q | take;
    new_d     = take & ~new_mask;
    match_d   = take & (cand == match_value) & ~match_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_msg_q <= '0;
      acc_vld_q <= 1'b0;
      new_q     <= 1'b0;
      match_q   <= 1'b0;
    end else begin
      acc_msg_q <= acc_msg_d;
      acc_vld_q <= acc_vld_d;
      new_q     <= new_d;
      match_q   <= match_d;
    end
  end

  assign msg_out     = acc_msg_q;
  assign msg_valid   = acc_vld_q;
  assign new_pulse   = new_q;
  assign match_pulse = match_q;
endmodule

// File: rtl/bom_rx_chk.sv
module bom_rx_chk
  import bom_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_valid,
  input logic [BOM_MSG_W-1:0] match_value,
  input logic                 new_mask,
  input logic                 match_mask,
  input logic [BOM_MSG_W-1:0] msg_out,
  input logic                 msg_valid,
  input logic                 new_pulse,
  input logic                 match_pulse
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!msg_valid && !new_pulse && !match_pulse); // R1
    end
  end

  AST_NEW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    new_pulse |=> !new_pulse); // R10
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse); // R10
  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (new_pulse || match_pulse) |-> $past(bit_valid)); // R9
  AST_NEW_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    new_pulse |-> (msg_valid && (!$past(msg_valid) || msg_out != $past(msg_out)))); // R6
  AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> (msg_valid && msg_out == $past(match_value))); // R7
  AST_NEW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(new_mask) |-> !new_pulse); // R8
  AST_MATCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(match_mask) |-> !match_pulse); // R8
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_valid) |-> ($stable(msg_out) && $stable(msg_valid))); // R9
endmodule

bind bom_rx bom_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .match_value(match_value),
  .new_mask(new_mask), .match_mask(match_mask), .msg_out(msg_out),
  .msg_valid(msg_valid), .new_pulse(new_pulse), .match_pulse(match_pulse)
);

// File: tb/bom_rx_tb.sv
module bom_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] MA = 6'h0D, MB = 6'h32, MC = 6'h07;
  localparam int NV = 20;
  // {junk, msg, exp_new, exp_match, exp_valid, exp_msg}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MB, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b1, 6'h00, 1'b0, 1'b0, 1'b0, 6'h00},
    {1'b0, MA, 1'b1, 1'b0, 1'b1, MA},
    {1'b0, MA, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MA},
    {1'b0, MB, 1'b1, 1'b1, 1'b1, MB},
    {1'b0, MB, 1'b0, 1'b0, 1'b1, MB}
  };

  logic       clk = 1'b0;
  logic       rst_n, bit_valid, bit_in, new_mask, match_mask;
  logic [5:0] match_value, msg_out;
  logic       msg_valid, new_pulse, match_pulse;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;
  logic       s_new, s_match, s_new2, s_match2;

  always #(CLK_PERIOD/2) clk = ~clk;

  bom_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .match_value(match_value), .new_mask(new_mask), .match_mask(match_mask),
    .msg_out(msg_out), .msg_valid(msg_valid), .new_pulse(new_pulse),
    .match_pulse(match_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [5:0] m);
    return {8'hFF, 1'b0, m, 1'b0};
  endfunction

  // each bit: one strobed cycle, then one idle cycle with bit_in flipped (R9)
  task automatic send_bits(input logic [15:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = w[i];
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in    = ~w[i];
      if (i == 0) begin
        s_new   = new_pulse;
        s_match = match_pulse;
        @(negedge clk);
        s_new2   = new_pulse;
        s_match2 = match_pulse;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(msg_valid), 0);
    chk("R1 pulses in reset", 32'({new_pulse, match_pulse}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(msg_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    new_mask = 1'b0; match_mask = 1'b0; match_value = MB;
    do_reset();

    // table walk: R2 R3 R4 R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      e = VEC[v];
      send_bits(e[15] ? 16'h0000 : cw(e[14:9]), 16);
      chk("R4/R6 new event", 32'(s_new), 32'(e[8]));
      chk("R7 match event", 32'(s_match), 32'(e[7]));
      chk("R3/R5 msg_valid", 32'(msg_valid), 32'(e[6]));
      if (e[6]) chk("R2/R5 msg_out", 32'(msg_out), 32'(e[5:0]));
      if (e[8]) chk("R10 pulse width", 32'({s_new2, s_match2}), 0);
    end

    // R11 R3 R6: leading junk bits at an odd offset, then exactly 7 then 8 codewords
    do_reset();
    send_bits(16'b10110, 5);
    for (int k = 0; k < 7; k++) send_bits(cw(MA), 16);
    chk("R3 seven positions", 32'({s_new, msg_valid}), 0);
    send_bits(cw(MA), 16);
    chk("R6 first after reset", 32'(s_new), 1);
    chk("R11 realigned msg", 32'(msg_out), 32'(MA));
    chk("R7 no match on differ", 32'(s_match), 0);

    // R8: masks suppress events, state still moves
    new_mask = 1'b1; match_mask = 1'b1; match_value = MC;
    for (int k = 0; k < 8; k++) send_bits(cw(MC), 16);
    chk("R8 masked pulses", 32'({s_new, s_match}), 0);
    chk("R8 msg updates", 32'(msg_out), 32'(MC));
    new_mask = 1'b0; match_mask = 1'b0; match_value = MA;
    for (int k = 0; k < 8; k++) send_bits(cw(MA), 16);
    chk("R8 unmasked new", 32'(s_new), 1);
    chk("R7 match after unmask", 32'(s_match), 1);
    chk("R10 pulses clear", 32'({s_new2, s_match2}), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule